// File: doc/BRIEF.md
# Threshold Trigger Matcher

The block keeps a table of sixteen 32-bit thresholds. Every clock it compares one running 32-bit quantity against all of them in parallel. A source-select input chooses that quantity. It is either an externally supplied measurement value or an internal free-running timer that advances once per clock (20 ns steps in the target system).

An entry takes part only while its bit in a 16-bit enable mask is set. An enabled entry fires the first time the quantity is at or above its threshold. After that the entry is spent until a phase-start pulse re-arms the whole table. The same phase-start pulse also restarts the timer from zero. The matches of all entries in one cycle are merged into a single registered trigger pulse. A simple indexed write port loads the thresholds. Decoding of the surrounding register bus is done elsewhere.

Top module: `thrtrig_matcher`

## Requirements
- R1: After reset `trig_out` is 0, the timer is 0, every entry is armed and every threshold holds 32'hFFFF_FFFF. No value below 32'hFFFF_FFFF fires an entry until it is written.
- R2: A write with `wr_en`=1 loads `wr_data` into the entry numbered `wr_idx` (0 to 15) at that clock edge. Comparisons in the cycle of the write still use the old threshold; the new threshold applies from the next cycle on.
- R3: Entry n can fire only while `en_mask[n]`=1. A disabled entry stays armed and can fire later, once its mask bit is set.
- R4: With `src_sel`=0 the compared quantity is `ext_val`; with `src_sel`=1 it is the internal timer.
- R5: The timer is cleared to 0 at a clock edge where `phase_start`=1, and otherwise increments by one at every clock edge.
- R6: An armed, enabled entry matches when the compared quantity, taken as unsigned, is greater than or equal to its threshold (equality included). `trig_out` is 1 in the cycle that follows the clock edge at which the match was sampled.
- R7: A matching entry becomes spent and does not fire again before the next `phase_start`, even if it is rewritten.
- R8: `phase_start`=1 suppresses every match in its own cycle and re-arms all entries from the next cycle on.
- R9: Any number of entries matching in the same cycle produces one `trig_out` pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timer step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Threshold write strobe |
| wr_idx | input | 4 | Threshold entry number to write |
| wr_data | input | 32 | Threshold value to write |
| en_mask | input | 16 | Per-entry enable, bit n for entry n |
| src_sel | input | 1 | 0: external value, 1: internal timer |
| ext_val | input | 32 | External measured value |
| phase_start | input | 1 | Restarts the timer and re-arms all entries |
| trig_out | output | 1 | Registered one-cycle trigger pulse |

## Verification
A corrupted threshold, a lost or stuck spent flag, or a timer that is off by one all show up on `trig_out`. The pulse appears one cycle early or late, goes missing, or repeats. Each of these faults is visible within one cycle of the comparison it spoils. The bench runs a cycle-by-cycle model of the table, the flags and the timer, and checks `trig_out` in every cycle. The scenarios use the exact equality boundary, values on either side of the unsigned sign bit, masked entries, rewrites of spent entries, and phase starts that arrive while a match is pending. These make timing and arming faults show within a few cycles.

// File: rtl/thrtrig_pkg.sv
package thrtrig_pkg;
  localparam int unsigned TT_ENTRIES = 16;
  localparam int unsigned TT_VAL_W   = 32;
endpackage

// File: rtl/thrtrig_rst_sync.sv
module thrtrig_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/thrtrig_timebase.sv
module thrtrig_timebase #(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [VAL_W-1:0] count
);
  logic [VAL_W-1:0] count_q, count_d;

  always_comb begin
    if (restart) count_d = '0;
    else         count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count_q == '0); // R5
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> count_q == $past(count_q) + 1'b1); // R5
endmodule

// File: rtl/thrtrig_lane.sv
module thrtrig_lane #(
  parameter int unsigned VAL_W = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LANE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             enable,
  input  logic             restart,
  input  logic [VAL_W-1:0] qty,
  output logic             hit
);
  logic [VAL_W-1:0] thr_q;
  logic             spent_q, spent_d;
  logic             wr_sel;

  assign wr_sel = wr_en && (wr_idx == IDX_W'(LANE));
  assign hit    = enable && !spent_q && !restart && (qty >= thr_q);

  always_comb begin
    spent_d = spent_q;
    if (restart)  spent_d = 1'b0;
    else if (hit) spent_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '1;
    else if (wr_sel) thr_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spent_q <= 1'b0;
    else        spent_q <= spent_d;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> thr_q == $past(wr_data)); // R2
  AST_SPENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_q && !restart) |=> spent_q); // R7
  AST_RESTART_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !spent_q); // R8
  AST_MASKED_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !spent_q) |=> !spent_q); // R3
endmodule

// File: rtl/thrtrig_matcher.sv
module thrtrig_matcher #(
  parameter int unsigned N_ENTRIES = thrtrig_pkg::TT_ENTRIES,
  parameter int unsigned VAL_W     = thrtrig_pkg::TT_VAL_W,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VAL_W-1:0]     wr_data,
  input  logic [N_ENTRIES-1:0] en_mask,
  input  logic                 src_sel,
  input  logic [VAL_W-1:0]     ext_val,
  input  logic                 phase_start,
  output logic                 trig_out
);
  logic                 rst_int_n;
  logic [VAL_W-1:0]     timer_val;
  logic [VAL_W-1:0]     qty;
  logic [N_ENTRIES-1:0] lane_hit;
  logic                 trig_q, trig_d;

  thrtrig_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  thrtrig_timebase #(.VAL_W(VAL_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (phase_start),
    .count   (timer_val)
  );

  assign qty = src_sel ? timer_val : ext_val;

  for (genvar n = 0; n < N_ENTRIES; n++) begin : g_lane
    thrtrig_lane #(.VAL_W(VAL_W), .IDX_W(IDX_W), .LANE(n)) u_lane (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .enable  (en_mask[n]),
      .restart (phase_start),
      .qty     (qty),
      .hit     (lane_hit[n])
    );
  end

  assign trig_d = |lane_hit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) trig_q <= 1'b0;
    else            trig_q <= trig_d;
  end

  assign trig_out = trig_q;

  AST_NO_TRIG_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_int_n)
    phase_start |=> !trig_out); // R8
  AST_MASKED_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_mask == '0) |=> !trig_out); // R3
endmodule

// File: tb/thrtrig_matcher_bench.sv
module thrtrig_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] en_mask = '0;
  logic        src_sel = 1'b0;
  logic [31:0] ext_val = '0;
  logic        phase_start = 1'b0;
  logic        trig_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  logic [31:0] m_thr [16];
  bit          m_spent [16];
  logic [31:0] m_timer;

  always #2 clk = ~clk;

  thrtrig_matcher u_thrtrig_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .en_mask(en_mask), .src_sel(src_sel), .ext_val(ext_val),
    .phase_start(phase_start), .trig_out(trig_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: trig_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected trig_out.
  task automatic step(input logic ps, input logic sel, input logic [31:0] ext,
                      input logic [15:0] mask, input logic we, input logic [3:0] idx,
                      input logic [31:0] wd, input string tag);
    logic [31:0] q;
    logic        hit;
    sb_item_t    it;
    @(negedge clk);
    phase_start = ps; src_sel = sel; ext_val = ext; en_mask = mask;
    wr_en = we; wr_idx = idx; wr_data = wd;
    q = sel ? m_timer : ext;
    hit = 1'b0;
    for (int n = 0; n < 16; n++) begin
      if (!ps && mask[n] && !m_spent[n] && q >= m_thr[n]) begin
        hit = 1'b1;
        m_spent[n] = 1'b1;
      end
      if (ps) m_spent[n] = 1'b0;
    end
    if (we) m_thr[idx] = wd;
    m_timer = ps ? 32'd0 : m_timer + 32'd1;
    it.exp = hit; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares the registered output after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(trig_out, it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) begin
      m_thr[n] = 32'hFFFF_FFFF;
      m_spent[n] = 1'b0;
    end
    m_timer = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(trig_out, 1'b0, "R1 reset output");

    // R1: reset thresholds are all ones
    step(1, 0, 32'h0, 16'hFFFF, 0, 0, 0, "R1");
    step(0, 0, 32'hFFFF_FFFE, 16'hFFFF, 0, 0, 0, "R1 below reset threshold");
    step(0, 0, 32'hFFFF_FFFE, 16'hFFFF, 0, 0, 0, "R1");

    // R2: write takes effect on the next cycle; R7 spent entry
    step(1, 0, 32'd0, 16'h0020, 0, 0, 0, "R8");
    step(0, 0, 32'd60, 16'h0020, 1, 4'd5, 32'd50, "R2 old threshold in write cycle");
    step(0, 0, 32'd60, 16'h0020, 0, 0, 0, "R2 new threshold applies");
    step(0, 0, 32'd200, 16'h0020, 0, 0, 0, "R7 no refire");
    step(0, 0, 32'd200, 16'h0020, 1, 4'd5, 32'd10, "R7 rewrite");
    step(0, 0, 32'd200, 16'h0020, 0, 0, 0, "R7 rewrite does not rearm");

    // R3: masked entry stays armed
    step(1, 0, 32'd0, 16'h0000, 1, 4'd3, 32'd100, "R8");
    step(0, 0, 32'd150, 16'h0000, 0, 0, 0, "R3 masked");
    step(0, 0, 32'd150, 16'h0000, 0, 0, 0, "R3 masked");
    step(0, 0, 32'd150, 16'h0008, 0, 0, 0, "R3 enabled later fires");
    step(0, 0, 32'd150, 16'h0008, 0, 0, 0, "R3");

    // R9: multiple simultaneous matches give one pulse
    step(1, 0, 32'd0, 16'h0007, 1, 4'd0, 32'd20, "R8");
    step(0, 0, 32'd0, 16'h0007, 1, 4'd1, 32'd20, "R9");
    step(0, 0, 32'd0, 16'h0007, 1, 4'd2, 32'd20, "R9");
    step(0, 0, 32'd25, 16'h0007, 0, 0, 0, "R9 merged pulse");
    step(0, 0, 32'd25, 16'h0007, 0, 0, 0, "R9 single cycle");

    // R6: unsigned compare across bit 31, equality included
    step(1, 0, 32'd0, 16'h0100, 1, 4'd8, 32'h8000_0000, "R8");
    step(0, 0, 32'h7FFF_FFFF, 16'h0100, 0, 0, 0, "R6 below");
    step(0, 0, 32'h8000_0000, 16'h0100, 0, 0, 0, "R6 equal");
    step(0, 0, 32'hF000_0000, 16'h0100, 0, 0, 0, "R6");

    // R8: phase start suppresses a pending match, rearms next cycle
    step(1, 0, 32'hFFFF_FFF0, 16'h0100, 0, 0, 0, "R8 suppressed");
    step(0, 0, 32'hFFFF_FFF0, 16'h0100, 0, 0, 0, "R8 rearmed");

    // R4 / R5: timer source, fires exactly at threshold count
    step(1, 1, 32'hFFFF_FFFF, 16'h0080, 1, 4'd7, 32'd10, "R5 restart");
    for (int k = 0; k < 14; k++) step(0, 1, 32'hFFFF_FFFF, 16'h0080, 0, 0, 0, "R5 R4 timer");
    step(1, 1, 32'd0, 16'h0080, 0, 0, 0, "R5 restart again");
    for (int k = 0; k < 12; k++) step(0, 1, 32'd0, 16'h0080, 0, 0, 0, "R5 R4 timer");
    step(0, 0, 32'd0, 16'h0000, 0, 0, 0, "R4");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule